// File: doc/BRIEF.md
# Stereo Serial Audio Receive Port

This block sits in front of a two-channel digital-to-analog converter core. It takes a serial audio stream made of a bit clock, a left/right frame clock and a data line, all running on their own external timing. It samples them on the system clock and rebuilds one signed 16-bit word per channel. The core receives both words at the same moment, together with a one-cycle strobe. Words arrive MSB first and are right-justified in each half frame. Whatever number of bit slots a half frame has, the word is the last 16 bits received before the frame clock changes level. The frame clock is high while the left word is sent.

Capture is double-buffered. Each finished channel word goes into a holding register. The held pair moves into the output registers together, once per frame, so the core never sees a left word from one frame next to a right word from another. The timing of that transfer depends on the mode input. In arbitrary-timing mode, every rising edge of the frame clock triggers a transfer. In standard mode, an internal frame counter triggers the transfer. That counter is snapped to the frame clock on the first few rising edges after reset and then runs freely, so standard mode expects the frame clock to be locked to the system clock.

Reset is active low and synchronous. It should be held for at least 16 system-clock cycles.

Top module: `sip_rx_port`

## Requirements
- R1: While reset is asserted, `left_word` and `right_word` read 0 and `pair_valid` is low.
- R2: The delivered word is the last 16 bits sampled on bit-clock rising edges before the frame clock changes level, MSB first. Any earlier bits of the half frame are ignored, for 16, 20, 24 or 32 bit slots per half frame.
- R3: The word that ends at a falling edge of the frame clock (the high half) is the left word. The word that ends at a rising edge (the low half) is the right word.
- R4: Both words of one frame appear on the outputs in the same cycle, marked by `pair_valid` high for exactly one cycle. The outputs do not change in cycles where `pair_valid` is low.
- R5: With `mode_arb` = 1 (arbitrary timing), one pair is delivered for every rising edge of the frame clock. No pair is delivered while the frame clock does not toggle.
- R6: With `mode_arb` = 0 (standard), the internal frame counter of `FRAME_CLKS` system clocks is re-aligned on the first `ALIGN_EDGES` (4) rising frame-clock edges after reset and runs freely afterwards. A pair is then delivered every `FRAME_CLKS` cycles even if the frame clock stops.
- R7: With `mode_arb` = 0, no pair is delivered after reset until the first rising edge of the frame clock.
- R8: Words pass through unchanged as 16-bit two's complement codes, including 0x8000, 0x7FFF, 0xFFFF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_arb | input | 1 | 1 = arbitrary timing, 0 = standard framing; change only under reset |
| bit_clk | input | 1 | External serial bit clock, data sampled on its rising edge |
| lr_clk | input | 1 | External frame clock, high during the left half frame |
| sdata | input | 1 | Serial data, MSB first, right-justified |
| left_word | output | 16 | Left sample handed to the converter core |
| right_word | output | 16 | Right sample handed to the converter core |
| pair_valid | output | 1 | One-cycle strobe marking a new stereo pair |

## Verification
Standard mode is run at 64 and 32 bit clocks per frame. Arbitrary mode is run at 48 bit clocks per frame and at 40 bit clocks per frame. Together these show that the padding slots before each right-justified word are dropped whatever their count. Word pairs with different left and right values, including the extreme two's complement codes, show that the channels are not swapped and that no bit is lost at the sign position. In each mode the frame clock is then held still: standard mode must keep producing strobes from its free-running counter, while arbitrary mode must fall silent. This separates the two transfer sources. A quiet period in standard mode before the first frame edge shows that the counter waits for its first alignment.

// File: rtl/sip_pkg.sv
// Shared definitions for the serial audio receive port.
package sip_pkg;
    // Transfer timing selection, sampled from the mode input.
    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_ARB = 1'b1
    } sip_mode_e;
endpackage

// File: rtl/sip_sync.sv
// Multi-bit level synchronizer for the external serial inputs.
// Assumes each bit is an independent slow signal (several system clocks
// per level), so bit-to-bit skew of one cycle is harmless.
module sip_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/sip_shift.sv
// Serial-to-parallel capture with per-channel holding registers.
// Assumes shift_en pulses once per bit-clock rising edge and the frame
// edge pulses arrive after the last bit of a half frame was shifted.
module sip_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              lr_rise,
    input  logic              lr_fall,
    output logic [WORD_W-1:0] left_hold,
    output logic [WORD_W-1:0] right_hold
);
    logic [WORD_W-1:0] shreg;

    // Keep only the most recent WORD_W bits, MSB arriving first.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[WORD_W-2:0], bit_in};
    end

    // End of the high half: freeze the left word.
    always_ff @(posedge clk) begin
        if (!rst_n)       left_hold <= '0;
        else if (lr_fall) left_hold <= shreg;
    end

    // End of the low half: freeze the right word.
    always_ff @(posedge clk) begin
        if (!rst_n)       right_hold <= '0;
        else if (lr_rise) right_hold <= shreg;
    end
endmodule

// File: rtl/sip_frame_align.sv
// Free-running frame counter re-aligned to the frame clock only on the
// first ALIGN_EDGES rising edges after reset. Assumes the frame clock is
// locked to the system clock with a period of FRAME_CLKS cycles.
module sip_frame_align #(
    parameter int FRAME_CLKS  = 512,
    parameter int ALIGN_EDGES = 4,
    localparam int CW = $clog2(FRAME_CLKS),
    localparam int AW = $clog2(ALIGN_EDGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lr_rise,
    output logic          align_now,
    output logic          ctr_zero,
    output logic [AW-1:0] align_cnt
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

    logic [CW-1:0] frame_ctr;

    assign align_now = lr_rise && (align_cnt < AW'(ALIGN_EDGES));
    assign ctr_zero  = (frame_ctr == '0);

    // Count alignments, saturating at ALIGN_EDGES.
    always_ff @(posedge clk) begin
        if (!rst_n)         align_cnt <= '0;
        else if (align_now) align_cnt <= align_cnt + AW'(1);
    end

    // Frame position: snapped on alignment, wraps at FRAME_CLKS.
    always_ff @(posedge clk) begin
        if (!rst_n)                frame_ctr <= '0;
        else if (align_now)        frame_ctr <= CW'(1);
        else if (frame_ctr == LAST) frame_ctr <= '0;
        else                       frame_ctr <= frame_ctr + CW'(1);
    end
endmodule

// File: rtl/sip_rx_port.sv
// Stereo serial audio receive port: synchronizes the external serial
// clocks, captures right-justified words and hands a simultaneous
// left/right pair to the converter core once per frame. The mode input
// must only change while reset is asserted.
module sip_rx_port #(
    parameter int WORD_W      = 16,
    parameter int FRAME_CLKS  = 512,
    parameter int ALIGN_EDGES = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(ALIGN_EDGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_arb,
    input  logic              bit_clk,
    input  logic              lr_clk,
    input  logic              sdata,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_valid
);
    import sip_pkg::*;

    localparam int IDX_BCK = 0;
    localparam int IDX_LR  = 1;
    localparam int IDX_DAT = 2;

    logic [2:0]        sync_lvl;
    logic              bck_prev, lr_prev;
    logic              bck_rise, lr_rise, lr_fall;
    logic              align_now, ctr_zero, std_tick, xfer_now, xfer_d;
    logic [AW-1:0]     align_cnt;
    logic [WORD_W-1:0] left_hold, right_hold;
    sip_mode_e         mode;

    assign mode = sip_mode_e'(mode_arb);

    sip_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdata, lr_clk, bit_clk}),
        .level    (sync_lvl)
    );

    // Remember previous synchronized clock levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bck_prev <= 1'b0;
            lr_prev  <= 1'b0;
        end else begin
            bck_prev <= sync_lvl[IDX_BCK];
            lr_prev  <= sync_lvl[IDX_LR];
        end
    end

    assign bck_rise = sync_lvl[IDX_BCK] & ~bck_prev;
    assign lr_rise  = sync_lvl[IDX_LR]  & ~lr_prev;
    assign lr_fall  = ~sync_lvl[IDX_LR] &  lr_prev;

    sip_shift #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (bck_rise),
        .bit_in     (sync_lvl[IDX_DAT]),
        .lr_rise    (lr_rise),
        .lr_fall    (lr_fall),
        .left_hold  (left_hold),
        .right_hold (right_hold)
    );

    sip_frame_align #(.FRAME_CLKS(FRAME_CLKS), .ALIGN_EDGES(ALIGN_EDGES)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .lr_rise   (lr_rise),
        .align_now (align_now),
        .ctr_zero  (ctr_zero),
        .align_cnt (align_cnt)
    );

    // Standard mode fires on alignment or at each counter wrap once aligned.
    assign std_tick = align_now || (ctr_zero && (align_cnt != '0));
    assign xfer_now = (mode == MODE_ARB) ? lr_rise : std_tick;

    // Delay the transfer one cycle so the right holding register is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_d <= 1'b0;
        else        xfer_d <= xfer_now;
    end

    // Move the held stereo pair to the core side together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= xfer_d;
            if (xfer_d) begin
                left_word  <= left_hold;
                right_word <= right_hold;
            end
        end
    end
endmodule

// File: rtl/sip_rx_port_chk.sv
// Property checker for the serial audio receive port, bound to the top.
module sip_rx_port_chk #(
    parameter int WORD_W      = 16,
    parameter int ALIGN_EDGES = 4,
    parameter int AW          = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pair_valid,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word,
    input logic [AW-1:0]     align_cnt
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid); // R4
    AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> $stable(left_word)); // R4
    AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> $stable(right_word)); // R4
    AST_ALIGN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        align_cnt <= AW'(ALIGN_EDGES)); // R6
    AST_ALIGN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (align_cnt != $past(align_cnt)) |-> (align_cnt == $past(align_cnt) + AW'(1))); // R6
endmodule

bind sip_rx_port sip_rx_port_chk #(
    .WORD_W(WORD_W), .ALIGN_EDGES(ALIGN_EDGES), .AW(AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pair_valid (pair_valid),
    .left_word  (left_word),
    .right_word (right_word),
    .align_cnt  (align_cnt)
);

// File: tb/tb_sip_rx_port.sv
module tb_sip_rx_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_arb = 1'b0;
    logic        bit_clk = 1'b0;
    logic        lr_clk = 1'b0;
    logic        sdata = 1'b0;
    logic [15:0] left_word, right_word;
    logic        pair_valid;

    always #2.5 clk = ~clk;  // 200 MHz

    sip_rx_port dut (
        .clk(clk), .rst_n(rst_n), .mode_arb(mode_arb),
        .bit_clk(bit_clk), .lr_clk(lr_clk), .sdata(sdata),
        .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q [$];
    logic [15:0] prev_l, prev_r;
    bit          count_mode = 1'b0;
    int          free_cnt = 0;
    string       cur_req = "R2";

    task automatic do_check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe, or just counts strobes.
    always @(negedge clk) begin
        if (rst_n && pair_valid && !done) begin
            if (count_mode) free_cnt++;
            else if (exp_q.size() == 0) do_check(1'b0, "R4 unexpected pair", {left_word, right_word}, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                do_check({left_word, right_word} === e, cur_req, {left_word, right_word}, e);
            end
        end
    end

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; mode_arb = mode; lr_clk = 1'b0; bit_clk = 1'b0; sdata = 1'b0;
        exp_q.delete(); prev_l = 16'h0; prev_r = 16'h0;
        repeat (20) @(negedge clk);
        // R1: reset state
        do_check({left_word, right_word, 7'b0, pair_valid} === 40'h0 ? 1'b1 : 1'b0, "R1",
                 {left_word, right_word}, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // One half frame: pad slots then the word, right-justified, MSB first.
    task automatic send_half(input logic lr, input logic [15:0] w, input int bits, input int cpb);
        for (int i = 0; i < bits; i++) begin
            lr_clk = lr; bit_clk = 1'b0;
            sdata = (i < bits - 16) ? ~i[0] : w[15 - (i - (bits - 16))];
            repeat (cpb / 2) @(negedge clk);
            bit_clk = 1'b1;
            repeat (cpb - cpb / 2) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int bits, input int cpb);
        exp_q.push_back({prev_l, prev_r});  // rising edge hands over previous frame
        send_half(1'b1, l, bits, cpb);
        send_half(1'b0, r, bits, cpb);
        prev_l = l; prev_r = r;
    endtask

    task automatic close_stream(input int cpb);
        exp_q.push_back({prev_l, prev_r});
        lr_clk = 1'b1; bit_clk = 1'b0;
        repeat (cpb) @(negedge clk);
        repeat (20) @(negedge clk);
        do_check(exp_q.size() == 0, "R4 pairs delivered", 32'(exp_q.size()), 32'h0);
        do_check({left_word, right_word} === {prev_l, prev_r}, "R4 hold",
                 {left_word, right_word}, {prev_l, prev_r});
    endtask

    task automatic strobe_window(input int cycles, input int expect_n, input string req);
        count_mode = 1'b1; free_cnt = 0;
        repeat (cycles) @(negedge clk);
        count_mode = 1'b0;
        do_check(free_cnt == expect_n, req, 32'(free_cnt), 32'(expect_n));
    endtask

    initial begin
        @(negedge clk);
        // Standard mode, 64 bit clocks per frame: R2 R3 R8
        do_reset(1'b0);
        cur_req = "R2/R3/R8 std 64fs";
        send_frame(16'h1234, 16'hABCD, 32, 8);
        send_frame(16'h8000, 16'h7FFF, 32, 8);
        send_frame(16'hFFFF, 16'h0001, 32, 8);
        send_frame(16'h0000, 16'hFFFF, 32, 8);
        send_frame(16'h5A5A, 16'hA5A5, 32, 8);
        send_frame(16'h7FFF, 16'h8000, 32, 8);
        close_stream(8);
        // R6: frame clock held, counter keeps producing pairs
        strobe_window(2560, 5, "R6 free-run strobes");

        // R7: standard mode waits for the first frame edge
        do_reset(1'b0);
        strobe_window(1500, 0, "R7 no strobe before first edge");
        cur_req = "R2/R3 std 32fs";
        send_frame(16'hC3C3, 16'h3C3C, 16, 16);
        send_frame(16'h0F0F, 16'hF0F0, 16, 16);
        send_frame(16'h8001, 16'h7FFE, 16, 16);
        send_frame(16'h0002, 16'hFFFE, 16, 16);
        close_stream(16);

        // Arbitrary mode, 48 bit clocks per frame: R5 R2
        do_reset(1'b1);
        cur_req = "R5/R2 arb 48fs";
        send_frame(16'h1111, 16'h2222, 24, 10);
        send_frame(16'h8000, 16'h7FFF, 24, 10);
        send_frame(16'hDEAD, 16'hBEEF, 24, 10);
        close_stream(10);
        strobe_window(2560, 0, "R5 no strobe without edges");

        // Arbitrary mode, 40 bit clocks per frame, unrelated period
        do_reset(1'b1);
        cur_req = "R5/R3 arb 40fs";
        send_frame(16'h0001, 16'h8000, 20, 6);
        send_frame(16'hFFFF, 16'h0000, 20, 6);
        send_frame(16'h6789, 16'h9876, 20, 6);
        close_stream(6);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule